// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts hardware events for a processor cluster. It holds a parameterised number of 32-bit general counters, each programmed with an event number. It also holds one 64-bit counter that advances on every clock. Events arrive as a vector of single-cycle strobes, with one bit per event number. A counter counts a strobe only when its own enable bit and the global enable are both set. A counter that wraps sets a sticky overflow bit. A level interrupt is raised for every overflow bit whose interrupt enable is set.

Software reaches the block through a simple word-addressed register port. A read returns its data one cycle after the request, with a valid flag. The port gives access to the control word, set/clear views of the counter-enable and interrupt-enable masks, the read-to-clear overflow status, every counter and event number, and a constant 64-bit map of the common event numbers that are implemented.

Register map (word addresses):
- 0x00: control.
- 0x01 / 0x02: counter-enable set / clear.
- 0x03 / 0x04: interrupt-enable set / clear.
- 0x05: overflow status.
- 0x06 / 0x07: cycle counter, low / high word.
- 0x08 / 0x09: common-event map, low / high word.
- 0x20+k: general counter k.
- 0x40+k: event number of counter k.

Top module: `cluster_pmu`

## Requirements
- R1: After reset, every counter, every enable mask and the overflow status read as zero, the global enable reads 0 and irq_o is low.
- R2: The control word reads as follows: bit 0 is the global enable, bits 15:11 hold the number of general counters, bits 23:16 hold the identification code, bits 31:24 hold the implementer code, and bits 2:1 always read 0.
- R3: General counter k adds one on every cycle in which the strobe named by its event number is high, provided that bit k of the counter-enable mask and the global enable are both set. An event number of NUM_EVENTS or above never counts.
- R4: No counter changes while the global enable is clear, and counter k does not change while its counter-enable bit is clear.
- R5: Writing to a set address ORs the written ones into the mask. Writing to a clear address removes the written ones. Both addresses read back the mask. Only bits 0..N-1 and bit 31 can be held, so writing all ones to counter-enable set reads back 0x8000003F when N=6.
- R6: A general counter at 0xFFFFFFFF that counts once wraps to 0 and sets bit k of the overflow status.
- R7: The cycle counter is 64 bits wide, with its low word at 0x06 and its high word at 0x07. It adds one on every clock while enable bit 31 and the global enable are set, carries into the high word, and on a 64-bit wrap goes to 0 and sets overflow bit 31.
- R8: A read of the overflow status returns the bits that are set and clears them in the same access. An overflow arriving in the cycle of that read stays set.
- R9: irq_o is high exactly when some overflow bit and its interrupt-enable bit are both set. It stays high until the status is read or the enable is cleared.
- R10: Writing control bit 1 clears every general counter, and writing control bit 2 clears the cycle counter, on the edge of the write. The clear wins over a count in that cycle.
- R11: Addresses 0x08 and 0x09 return bits 31:0 and 63:32 of the COMMON_EVT_MAP parameter.
- R12: A counter write loads the value. A write to counter index N..30 has no effect, and that index reads 0.
- R13: rd_valid_o is high in exactly the cycle after each read request, with rdata_o valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 7 | Word address |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| evt_i | input | NUM_EVENTS | Single-cycle event strobes, bit n is event number n |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A counter that misses or doubles a strobe shows up in the first read that follows the stimulus, and that read returns its data one cycle later. A wrong enable gate shows up as a changed count in windows where nothing should count. An overflow bit that is lost or stays set shows up on irq_o in the cycle after the wrapping edge, or in the second of two back-to-back status reads. A fault in the carry of the cycle counter shows up in the high word after a preload just below the 32-bit boundary. Exact window lengths make an off-by-one in the enable timing visible in the low word.

// File: rtl/cluster_pmu_pkg.sv
package cluster_pmu_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int CYC_IDX = 31;

  localparam logic [ADDR_W-1:0] A_CTRL     = 7'h00;
  localparam logic [ADDR_W-1:0] A_CEN_SET  = 7'h01;
  localparam logic [ADDR_W-1:0] A_CEN_CLR  = 7'h02;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 7'h03;
  localparam logic [ADDR_W-1:0] A_IEN_CLR  = 7'h04;
  localparam logic [ADDR_W-1:0] A_OVF      = 7'h05;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 7'h06;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 7'h07;
  localparam logic [ADDR_W-1:0] A_CEID_LO  = 7'h08;
  localparam logic [ADDR_W-1:0] A_CEID_HI  = 7'h09;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 7'h40;

  // control word bit positions
  localparam int CTRL_EN      = 0;
  localparam int CTRL_RST_EVT = 1;
  localparam int CTRL_RST_CYC = 2;

  typedef struct packed {
    logic glob_en_d;
    logic rst_evt;
    logic rst_cyc;
  } ctrl_cmd_t;

  function automatic logic [DATA_W-1:0] impl_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < 31; k++) if (k < n) m[k] = 1'b1;
    m[CYC_IDX] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 64,
  parameter int SEL_W      = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic                  clr_i,
  input  logic                  cnt_we_i,
  input  logic                  sel_we_i,
  input  logic [CNT_W-1:0]      wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  ovf_o
);
  localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             hit, inc;

  always_comb begin
    hit = 1'b0;
    if (sel_q < SEL_W'(NUM_EVENTS)) hit = evt_i[sel_q[IDX_W-1:0]];
  end

  assign inc   = en_i & hit;
  assign ovf_o = inc & (&cnt_q) & ~clr_i & ~cnt_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (clr_i)         cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (inc)      cnt_q <= cnt_q + 1'b1;
      if (sel_we_i)      sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
  parameter int HALF_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic                ovf_o
);
  logic [2*HALF_W-1:0] cnt_q;
  logic                busy_wr;

  assign busy_wr = lo_we_i | hi_we_i;
  assign ovf_o   = en_i & (&cnt_q) & ~clr_i & ~busy_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (busy_wr) begin
      if (lo_we_i) cnt_q[HALF_W-1:0]        <= wdata_i;
      if (hi_we_i) cnt_q[2*HALF_W-1:HALF_W] <= wdata_i;
    end else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic         glob_en_d_i,
  input  logic         cen_set_i,
  input  logic         cen_clr_i,
  input  logic         ien_set_i,
  input  logic         ien_clr_i,
  input  logic [W-1:0] wmask_i,
  input  logic         ovf_rd_i,
  input  logic [W-1:0] ovf_new_i,
  output logic         glob_en_o,
  output logic [W-1:0] cen_o,
  output logic [W-1:0] ien_o,
  output logic [W-1:0] ovf_o,
  output logic         irq_o
);
  logic         glob_en_q;
  logic [W-1:0] cen_q, ien_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_q <= 1'b0;
      cen_q     <= '0;
      ien_q     <= '0;
      ovf_q     <= '0;
    end else begin
      if (ctrl_we_i) glob_en_q <= glob_en_d_i;
      if (cen_set_i) cen_q <= cen_q | wmask_i;
      if (cen_clr_i) cen_q <= cen_q & ~wmask_i;
      if (ien_set_i) ien_q <= ien_q | wmask_i;
      if (ien_clr_i) ien_q <= ien_q & ~wmask_i;
      // read-to-clear; a wrap in the same cycle survives
      ovf_q <= (ovf_rd_i ? '0 : ovf_q) | ovf_new_i;
    end
  end

  assign glob_en_o = glob_en_q;
  assign cen_o     = cen_q;
  assign ien_o     = ien_q;
  assign ovf_o     = ovf_q;
  assign irq_o     = |(ovf_q & ien_q);
endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu
  import cluster_pmu_pkg::*;
#(
  parameter int              NUM_EVT_CNT    = 6,
  parameter int              NUM_EVENTS     = 64,
  parameter int              SEL_W          = 10,
  parameter logic [7:0]      ID_CODE        = 8'h5A,
  parameter logic [7:0]      IMPL_CODE      = 8'h41,
  parameter logic [63:0]     COMMON_EVT_MAP = 64'h0000_0001_3E02_0800
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  rd_valid_o,
  input  logic [NUM_EVENTS-1:0] evt_i,
  output logic                  irq_o
);
  localparam logic [DATA_W-1:0] VALID_MASK = impl_mask(NUM_EVT_CNT);
  localparam logic [4:0]        N_FIELD    = 5'(NUM_EVT_CNT);

  logic wr, rd;
  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  ctrl_cmd_t cmd;
  logic      ctrl_we;
  assign ctrl_we       = wr && req_addr_i == A_CTRL;
  assign cmd.glob_en_d = req_wdata_i[CTRL_EN];
  assign cmd.rst_evt   = ctrl_we & req_wdata_i[CTRL_RST_EVT];
  assign cmd.rst_cyc   = ctrl_we & req_wdata_i[CTRL_RST_CYC];

  logic              glob_en;
  logic [DATA_W-1:0] cen, ien, ovf_stat, ovf_new;
  logic              ovf_rd;
  assign ovf_rd = rd && req_addr_i == A_OVF;

  pmu_ctrl_regs #(.W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we),
    .glob_en_d_i (cmd.glob_en_d),
    .cen_set_i   (wr && req_addr_i == A_CEN_SET),
    .cen_clr_i   (wr && req_addr_i == A_CEN_CLR),
    .ien_set_i   (wr && req_addr_i == A_IEN_SET),
    .ien_clr_i   (wr && req_addr_i == A_IEN_CLR),
    .wmask_i     (req_wdata_i & VALID_MASK),
    .ovf_rd_i    (ovf_rd),
    .ovf_new_i   (ovf_new),
    .glob_en_o   (glob_en),
    .cen_o       (cen),
    .ien_o       (ien),
    .ovf_o       (ovf_stat),
    .irq_o       (irq_o)
  );

  logic [DATA_W-1:0] cnt_arr [NUM_EVT_CNT];
  logic [SEL_W-1:0]  sel_arr [NUM_EVT_CNT];
  logic [NUM_EVT_CNT-1:0] evt_ovf;

  for (genvar k = 0; k < NUM_EVT_CNT; k++) begin : g_cnt
    localparam logic [ADDR_W-1:0] CNT_A = A_CNT_BASE | ADDR_W'(k);
    localparam logic [ADDR_W-1:0] SEL_A = A_SEL_BASE | ADDR_W'(k);
    pmu_evt_counter #(
      .CNT_W(DATA_W), .NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)
    ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (glob_en & cen[k]),
      .evt_i    (evt_i),
      .clr_i    (cmd.rst_evt),
      .cnt_we_i (wr && req_addr_i == CNT_A),
      .sel_we_i (wr && req_addr_i == SEL_A),
      .wdata_i  (req_wdata_i),
      .cnt_o    (cnt_arr[k]),
      .sel_o    (sel_arr[k]),
      .ovf_o    (evt_ovf[k])
    );
  end

  logic [2*DATA_W-1:0] cyc_cnt;
  logic                cyc_ovf;

  pmu_cyc_counter #(.HALF_W(DATA_W)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (glob_en & cen[CYC_IDX]),
    .clr_i   (cmd.rst_cyc),
    .lo_we_i (wr && req_addr_i == A_CYC_LO),
    .hi_we_i (wr && req_addr_i == A_CYC_HI),
    .wdata_i (req_wdata_i),
    .cnt_o   (cyc_cnt),
    .ovf_o   (cyc_ovf)
  );

  always_comb begin
    ovf_new = '0;
    for (int k = 0; k < NUM_EVT_CNT; k++) ovf_new[k] = evt_ovf[k];
    ovf_new[CYC_IDX] = cyc_ovf;
  end

  logic [DATA_W-1:0] rd_mux;
  logic [4:0]        idx;
  assign idx = req_addr_i[4:0];

  always_comb begin
    rd_mux = '0;
    unique case (req_addr_i[6:5])
      2'b00: begin
        case (req_addr_i)
          A_CTRL:    rd_mux = {IMPL_CODE, ID_CODE, N_FIELD, 10'd0, glob_en};
          A_CEN_SET, A_CEN_CLR: rd_mux = cen;
          A_IEN_SET, A_IEN_CLR: rd_mux = ien;
          A_OVF:     rd_mux = ovf_stat;
          A_CYC_LO:  rd_mux = cyc_cnt[DATA_W-1:0];
          A_CYC_HI:  rd_mux = cyc_cnt[2*DATA_W-1:DATA_W];
          A_CEID_LO: rd_mux = COMMON_EVT_MAP[31:0];
          A_CEID_HI: rd_mux = COMMON_EVT_MAP[63:32];
          default:   rd_mux = '0;
        endcase
      end
      2'b01: for (int k = 0; k < NUM_EVT_CNT; k++)
               if (idx == 5'(k)) rd_mux = cnt_arr[k];
      2'b10: for (int k = 0; k < NUM_EVT_CNT; k++)
               if (idx == 5'(k)) rd_mux = DATA_W'(sel_arr[k]);
      default: rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rvalid_q;
endmodule

// File: rtl/cluster_pmu_chk.sv
module cluster_pmu_chk
  import cluster_pmu_pkg::*;
#(
  parameter int          NUM_EVT_CNT    = 6,
  parameter logic [7:0]  ID_CODE        = 8'h5A,
  parameter logic [7:0]  IMPL_CODE      = 8'h41,
  parameter logic [63:0] COMMON_EVT_MAP = 64'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rd_valid_o,
  input logic              irq_o,
  input logic              glob_en_i,
  input logic [63:0]       cyc_cnt_i
);
  logic rd_req;
  assign rd_req = req_valid_i & ~req_write_i;

  // R13
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rd_valid_o);

  // R13
  no_rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rd_valid_o);

  // R2
  ctrl_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i == A_CTRL) |=>
      (rdata_o[31:16] == {IMPL_CODE, ID_CODE} &&
       rdata_o[15:11] == 5'(NUM_EVT_CNT) && rdata_o[2:1] == 2'b00));

  // R11
  ceid_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i == A_CEID_LO) |=> rdata_o == COMMON_EVT_MAP[31:0]);

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(rd_req && req_addr_i == A_OVF) &&
     !(req_valid_i && req_write_i && req_addr_i == A_IEN_CLR)) |=> irq_o);

  // R4
  cyc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && !(req_valid_i && req_write_i &&
      (req_addr_i == A_CYC_LO || req_addr_i == A_CYC_HI || req_addr_i == A_CTRL)))
    |=> $stable(cyc_cnt_i));
endmodule

bind cluster_pmu cluster_pmu_chk #(
  .NUM_EVT_CNT(NUM_EVT_CNT), .ID_CODE(ID_CODE),
  .IMPL_CODE(IMPL_CODE), .COMMON_EVT_MAP(COMMON_EVT_MAP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rdata_o     (rdata_o),
  .rd_valid_o  (rd_valid_o),
  .irq_o       (irq_o),
  .glob_en_i   (glob_en),
  .cyc_cnt_i   (cyc_cnt)
);

// File: tb/cluster_pmu_bench.sv
module cluster_pmu_bench;
  import cluster_pmu_pkg::*;

  localparam int          N    = 6;
  localparam int          NEV  = 64;
  localparam logic [63:0] CMAP = 64'h0000_0001_3E02_0800;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [6:0]      req_addr_i = '0;
  logic [31:0]     req_wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            rd_valid_o, irq_o;
  logic [NEV-1:0]  evt_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  cluster_pmu #(.NUM_EVT_CNT(N), .NUM_EVENTS(NEV), .SEL_W(10),
    .ID_CODE(8'h5A), .IMPL_CODE(8'h41), .COMMON_EVT_MAP(CMAP)) u_cluster_pmu (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .rdata_o, .rd_valid_o, .evt_i, .irq_o);

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare read results in order
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13: got unexpected read %h expected none", rdata_o);
      end else begin
        chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic pulse(input logic [NEV-1:0] m);
    evt_i = m;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  localparam logic [NEV-1:0] E5 = NEV'(1) << 5;
  localparam logic [NEV-1:0] E9 = NEV'(1) << 9;
  localparam logic [NEV-1:0] E7 = NEV'(1) << 7;

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk({31'd0, irq_o}, 0, "R1 irq");
    chk({31'd0, rd_valid_o}, 0, "R13 idle");
    rd(A_CTRL, 32'h415A_3000, "R1 ctrl");
    rd(A_OVF, 0, "R1 ovf");
    rd(A_CNT_BASE, 0, "R1 cnt0");
    rd(A_CEN_SET, 0, "R1 cen");
    rd(A_CYC_LO, 0, "R1 cyc");
    // R5 set/clear masks
    wr(A_CEN_SET, 32'hFFFF_FFFF);
    rd(A_CEN_SET, 32'h8000_003F, "R5 set");
    wr(A_CEN_CLR, 32'h8000_003C);
    rd(A_CEN_CLR, 32'h0000_0003, "R5 clr");
    // R12 writes
    wr(A_CNT_BASE | 7'd7, 32'h1234);
    rd(A_CNT_BASE | 7'd7, 0, "R12 unimpl");
    wr(A_CNT_BASE | 7'd2, 32'hDEAD_BEEF);
    rd(A_CNT_BASE | 7'd2, 32'hDEAD_BEEF, "R12 load");
    // event numbers
    wr(A_SEL_BASE | 7'd0, 5);
    wr(A_SEL_BASE | 7'd1, 9);
    rd(A_SEL_BASE | 7'd1, 9, "R3 sel");
    // R4 global off
    pulse(E5 | E9); pulse(E5 | E9);
    rd(A_CNT_BASE, 0, "R4 global off");
    // R3 counting
    wr(A_CTRL, 1);
    pulse(E5); pulse(E5); pulse(E5); pulse(E9); pulse(E5 | E9); pulse(E7);
    rd(A_CNT_BASE, 4, "R3 cnt0");
    rd(A_CNT_BASE | 7'd1, 2, "R3 cnt1");
    // R4 per-counter disable
    wr(A_CEN_CLR, 2);
    pulse(E5 | E9);
    rd(A_CNT_BASE, 5, "R4 cnt0 on");
    rd(A_CNT_BASE | 7'd1, 2, "R4 cnt1 off");
    // R6 / R9 wrap and interrupt
    wr(A_IEN_SET, 1);
    wr(A_CNT_BASE, 32'hFFFF_FFFE);
    pulse(E5);
    chk({31'd0, irq_o}, 0, "R9 before wrap");
    pulse(E5);
    chk({31'd0, irq_o}, 1, "R9 after wrap");
    rd(A_CNT_BASE, 0, "R6 wrap");
    chk({31'd0, irq_o}, 1, "R9 held");
    rd(A_OVF, 1, "R8 read");
    chk({31'd0, irq_o}, 0, "R8 cleared irq");
    rd(A_OVF, 0, "R8 cleared");
    // overflow without interrupt enable
    wr(A_CEN_SET, 2);
    wr(A_CNT_BASE | 7'd1, 32'hFFFF_FFFF);
    pulse(E9);
    chk({31'd0, irq_o}, 0, "R9 masked");
    rd(A_OVF, 2, "R6 ovf bit1");
    // R8 wrap in same cycle as read
    wr(A_CNT_BASE, 32'hFFFF_FFFF);
    wr(A_CNT_BASE | 7'd1, 32'hFFFF_FFFF);
    pulse(E9);
    evt_i = E5;
    rd(A_OVF, 2, "R8 same-cycle read");
    evt_i = '0;
    chk({31'd0, irq_o}, 1, "R9 new wrap");
    rd(A_OVF, 1, "R8 survivor");
    // R10 reset priority
    pulse(E5); pulse(E5);
    rd(A_CNT_BASE, 2, "R3 recount");
    evt_i = E5;
    wr(A_CTRL, 3);
    evt_i = '0;
    rd(A_CNT_BASE, 0, "R10 evt reset");
    rd(A_CTRL, 32'h415A_3001, "R2 ctrl");
    // R7 cycle counter
    wr(A_CTRL, 0);
    wr(A_CEN_SET, 32'h8000_0000);
    wr(A_CYC_LO, 32'hFFFF_FFFE);
    wr(A_CYC_HI, 0);
    wr(A_CTRL, 1);
    repeat (4) @(negedge clk_i);
    wr(A_CTRL, 0);
    rd(A_CYC_LO, 3, "R7 low");
    rd(A_CYC_HI, 1, "R7 carry");
    wr(A_CYC_LO, 32'hFFFF_FFFF);
    wr(A_CYC_HI, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);
    rd(A_CYC_LO, 0, "R7 wrap low");
    rd(A_CYC_HI, 0, "R7 wrap high");
    rd(A_OVF, 32'h8000_0000, "R7 ovf31");
    wr(A_CYC_LO, 32'h55);
    wr(A_CTRL, 4);
    rd(A_CYC_LO, 0, "R10 cyc reset");
    // R11 common event map
    rd(A_CEID_LO, CMAP[31:0], "R11 low");
    rd(A_CEID_HI, CMAP[63:32], "R11 high");
    repeat (3) @(negedge clk_i);
    chk(32'(exp_q.size()), 0, "R13 all reads returned");
    report();
  end
endmodule